// File: doc/BRIEF.md
# Context-Configured Processing Cell

A single coarse-grain processing element whose operation is chosen every clock by a 32-bit context word. Each cycle it picks two 16-bit operands, one from a wide selector (data bus, mesh neighbours, peers in the same row and column of the quadrant, the express lane or its own register file) and one from a narrow selector or its own output register. It can also use a signed 12-bit constant carried in the context word. It then computes an arithmetic, logic, multiply or multiply-accumulate result at 28-bit precision. It shifts that result, clamps it to a signed 16-bit value and writes it both to the output register and to one of four local registers.

The cell sits in a larger array, where a row or column controller broadcasts the same context word to many cells at once. When the cell's row or column is not selected, the enable input holds every register in the cell. The express-lane write flag is registered alongside the result, so the lane driver and the data it carries change on the same edge.

Top module: `rc_cell`

## Requirements
- R1: After the asynchronous active-low reset, `out_o` is 0, `xl_we_o` is 0, and the four local registers and the accumulator all read as 0.
- R2: Context field positions are: bit 31 express flag, bit 30 feedback select, bits 29:28 destination register, bit 27 shift direction, bits 26:23 shift amount, bits 22:19 operand A select, bits 18:16 operand B select, bits 15:12 opcode, bits 11:0 signed constant K. Operand A select codes: 0 data bus, 1 north, 2 south, 3 west, 4 east, 5..7 row peer slots 0..2, 8..10 column peer slots 0..2, 11 express-lane input, 12..15 registers R0..R3. Peer slot i occupies bits 16i+15:16i of its bus.
- R3: Operand B select codes are: 0..3 registers R0..R3, 4 data bus, 5 north, 6 south, 7 west. When the feedback bit is 1, operand B is the current output register instead.
- R4: Opcodes, with operands as signed 16-bit values and K as a signed 12-bit value: 0 pass A, 1 A+B, 2 A-B, 3 |A-B|, 4 A AND B, 5 A OR B, 6 A XOR B, 7 A+K, 11 pass B, 12 A-K. Codes 14 and 15 behave as pass A.
- R5: Opcode 8 gives the signed product A*K.
- R6: Opcode 9 adds A*K to a 28-bit accumulator, which wraps modulo 2^28, and yields the new accumulator value in the same cycle. Opcode 10 clears the accumulator and yields 0. Opcode 13 yields the accumulator without changing it. No other opcode changes the accumulator.
- R7: With a direction bit of 0, the 28-bit result is shifted left by the shift amount and truncated to 28 bits. With a direction bit of 1, it is shifted right arithmetically by the shift amount.
- R8: The shifted value is clamped to the range -32768..32767 before it is stored.
- R9: The clamped value is written to the register chosen by the destination field, where 0..3 select R0..R3. The other three registers keep their values.
- R10: `xl_we_o` takes the value of context bit 31 at each enabled clock edge.
- R11: While `en` is 0, the output register, express flag, local registers and accumulator all hold their values.
- R12: The result of a context word appears on `out_o` after the first rising edge at which that word is applied with `en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Cell enable; when low, all state is held |
| ctx | input | 32 | Context word for this cycle |
| dbus_i | input | 16 | Data bus operand |
| nbr_n_i | input | 16 | North neighbour output |
| nbr_s_i | input | 16 | South neighbour output |
| nbr_w_i | input | 16 | West neighbour output |
| nbr_e_i | input | 16 | East neighbour output |
| row_peer_i | input | 48 | Outputs of the three other cells in the quadrant row |
| col_peer_i | input | 48 | Outputs of the three other cells in the quadrant column |
| xl_i | input | 16 | Express-lane input |
| out_o | output | 16 | Registered, clamped result |
| xl_we_o | output | 1 | Registered express-lane write enable |

## Verification
The accumulator and the local registers cannot be seen at the ports. Their contents show up only when a later context reads them out, either through operand A codes 12..15 or through opcode 13. The stimulus therefore follows each multiply-accumulate run, register write or disabled stretch with read-back contexts. A run of three accumulations of -32768 times -2048 pushes the accumulator past 2^27 so that the wrap is exercised. Random context words, mixed with random enable gaps, then reach shift and clamp combinations that directed cases miss.

// File: rtl/rc_cell.sv
module rc_cell #(
  parameter int DW = 16,
  parameter int AW = 28,
  parameter int KW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [31:0]     ctx,
  input  logic [DW-1:0]   dbus_i,
  input  logic [DW-1:0]   nbr_n_i,
  input  logic [DW-1:0]   nbr_s_i,
  input  logic [DW-1:0]   nbr_w_i,
  input  logic [DW-1:0]   nbr_e_i,
  input  logic [3*DW-1:0] row_peer_i,
  input  logic [3*DW-1:0] col_peer_i,
  input  logic [DW-1:0]   xl_i,
  output logic [DW-1:0]   out_o,
  output logic            xl_we_o
);
  localparam logic signed [AW-1:0] SMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] SMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic          xl_f, fb_f, dir_f;
  logic [1:0]    dst_f;
  logic [3:0]    amt_f, sa_f, op_f;
  logic [2:0]    sb_f;
  logic [KW-1:0] k_f;

  assign xl_f  = ctx[31];
  assign fb_f  = ctx[30];
  assign dst_f = ctx[29:28];
  assign dir_f = ctx[27];
  assign amt_f = ctx[26:23];
  assign sa_f  = ctx[22:19];
  assign sb_f  = ctx[18:16];
  assign op_f  = ctx[15:12];
  assign k_f   = ctx[KW-1:0];

  logic [DW-1:0] rf [4];
  logic [DW-1:0] out_q;
  logic          xl_q;
  logic signed [AW-1:0] acc_q, acc_d;

  logic [DW-1:0] a, b, bsel;

  always_comb begin
    unique case (sa_f)
      4'd0:    a = dbus_i;
      4'd1:    a = nbr_n_i;
      4'd2:    a = nbr_s_i;
      4'd3:    a = nbr_w_i;
      4'd4:    a = nbr_e_i;
      4'd5:    a = row_peer_i[0*DW +: DW];
      4'd6:    a = row_peer_i[1*DW +: DW];
      4'd7:    a = row_peer_i[2*DW +: DW];
      4'd8:    a = col_peer_i[0*DW +: DW];
      4'd9:    a = col_peer_i[1*DW +: DW];
      4'd10:   a = col_peer_i[2*DW +: DW];
      4'd11:   a = xl_i;
      default: a = rf[sa_f[1:0]];
    endcase
  end

  always_comb begin
    unique case (sb_f)
      3'd4:    bsel = dbus_i;
      3'd5:    bsel = nbr_n_i;
      3'd6:    bsel = nbr_s_i;
      3'd7:    bsel = nbr_w_i;
      default: bsel = rf[sb_f[1:0]];
    endcase
  end

  assign b = fb_f ? out_q : bsel;

  logic signed [AW-1:0] ax, bx, kx, prod, diff, res, shf;
  logic [DW-1:0] sat;

  assign ax   = {{(AW-DW){a[DW-1]}}, a};
  assign bx   = {{(AW-DW){b[DW-1]}}, b};
  assign kx   = {{(AW-KW){k_f[KW-1]}}, k_f};
  assign prod = ax * kx;
  assign diff = ax - bx;

  always_comb begin
    acc_d = acc_q;
    unique case (op_f)
      4'd1:    res = ax + bx;
      4'd2:    res = diff;
      4'd3:    res = diff[AW-1] ? -diff : diff;
      4'd4:    res = ax & bx;
      4'd5:    res = ax | bx;
      4'd6:    res = ax ^ bx;
      4'd7:    res = ax + kx;
      4'd8:    res = prod;
      4'd9:    begin acc_d = acc_q + prod; res = acc_d; end
      4'd10:   begin acc_d = '0; res = '0; end
      4'd11:   res = bx;
      4'd12:   res = ax - kx;
      4'd13:   res = acc_q;
      default: res = ax;
    endcase
  end

  assign shf = dir_f ? (res >>> amt_f) : (res << amt_f);
  assign sat = (shf > SMAX) ? SMAX[DW-1:0] :
               (shf < SMIN) ? SMIN[DW-1:0] : shf[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      xl_q  <= 1'b0;
      acc_q <= '0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else if (en) begin
      out_q     <= sat;
      xl_q      <= xl_f;
      acc_q     <= acc_d;
      rf[dst_f] <= sat;
    end
  end

  assign out_o   = out_q;
  assign xl_we_o = xl_q;
endmodule

// File: rtl/rc_cell_chk.sv
module rc_cell_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        xl_flag,
  input logic [3:0]  op,
  input logic [4:0]  shf,
  input logic [15:0] out_o,
  input logic        xl_we_o
);
  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_o) && $stable(xl_we_o));

  // R10
  xl_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> xl_we_o == $past(xl_flag));

  // R4
  absd_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 4'd3 && (shf[4] || shf[3:0] == 4'd0) |=> !out_o[15]);

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 4'd10 |=> out_o == 16'd0);
endmodule

bind rc_cell rc_cell_chk i_rc_cell_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .xl_flag(ctx[31]), .op(ctx[15:12]),
  .shf(ctx[27:23]), .out_o(out_o), .xl_we_o(xl_we_o)
);

// File: tb/test_rc_cell.sv
module test_rc_cell;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] ctx = '0;
  logic [15:0] dbus_i = '0, nbr_n_i = '0, nbr_s_i = '0, nbr_w_i = '0, nbr_e_i = '0, xl_i = '0;
  logic [47:0] row_peer_i = '0, col_peer_i = '0;
  logic [15:0] out_o;
  logic xl_we_o;

  int vec = 0, bad = 0;
  longint m_rf[4] = '{0, 0, 0, 0};
  longint m_acc = 0, m_out = 0;
  bit m_xl = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rc_cell i_rc_cell (
    .clk(clk), .rst_n(rst_n), .en(en), .ctx(ctx), .dbus_i(dbus_i),
    .nbr_n_i(nbr_n_i), .nbr_s_i(nbr_s_i), .nbr_w_i(nbr_w_i), .nbr_e_i(nbr_e_i),
    .row_peer_i(row_peer_i), .col_peer_i(col_peer_i), .xl_i(xl_i),
    .out_o(out_o), .xl_we_o(xl_we_o)
  );

  function automatic longint s16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint wrap28(input longint v);
    longint t = v & 64'h0FFF_FFFF;
    if (t[27]) t = t - 64'h1000_0000;
    return t;
  endfunction

  function automatic logic [31:0] mk(input bit xl, input bit fb, input int dst, input bit dir,
                                     input int amt, input int sa, input int sb, input int op,
                                     input int k);
    return {xl, fb, 2'(dst), dir, 4'(amt), 4'(sa), 3'(sb), 4'(op), 12'(k)};
  endfunction

  task automatic compare(input string tag);
    vec++;
    if (s16(out_o) != m_out || xl_we_o != m_xl) begin
      bad++;
      $display("FAIL %s: out=%0d xl=%0b expected out=%0d xl=%0b",
               tag, s16(out_o), xl_we_o, m_out, m_xl);
    end
  endtask

  task automatic step(input string tag);
    longint a, b, k, r, an, sh, s;
    case (ctx[22:19])
      4'd0: a = s16(dbus_i);
      4'd1: a = s16(nbr_n_i);
      4'd2: a = s16(nbr_s_i);
      4'd3: a = s16(nbr_w_i);
      4'd4: a = s16(nbr_e_i);
      4'd5: a = s16(row_peer_i[15:0]);
      4'd6: a = s16(row_peer_i[31:16]);
      4'd7: a = s16(row_peer_i[47:32]);
      4'd8: a = s16(col_peer_i[15:0]);
      4'd9: a = s16(col_peer_i[31:16]);
      4'd10: a = s16(col_peer_i[47:32]);
      4'd11: a = s16(xl_i);
      default: a = m_rf[ctx[20:19]];
    endcase
    if (ctx[30]) b = m_out;
    else case (ctx[18:16])
      3'd4: b = s16(dbus_i);
      3'd5: b = s16(nbr_n_i);
      3'd6: b = s16(nbr_s_i);
      3'd7: b = s16(nbr_w_i);
      default: b = m_rf[ctx[17:16]];
    endcase
    k = longint'($signed(ctx[11:0]));
    an = m_acc;
    case (ctx[15:12])
      4'd1: r = a + b;
      4'd2: r = a - b;
      4'd3: r = (a > b) ? a - b : b - a;
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = a + k;
      4'd8: r = a * k;
      4'd9: begin an = wrap28(m_acc + a * k); r = an; end
      4'd10: begin an = 0; r = 0; end
      4'd11: r = b;
      4'd12: r = a - k;
      4'd13: r = m_acc;
      default: r = a;
    endcase
    if (ctx[27]) sh = r >>> ctx[26:23];
    else sh = wrap28(r << ctx[26:23]);
    s = (sh > 32767) ? 32767 : (sh < -32768) ? -32768 : sh;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      m_out = s;
      m_rf[ctx[29:28]] = s;
      m_acc = an;
      m_xl = ctx[31];
    end
    compare(tag);
  endtask

  task automatic go(input logic [31:0] c, input string tag);
    ctx = c;
    step(tag);
  endtask

  task automatic scramble();
    dbus_i = 16'($urandom); nbr_n_i = 16'($urandom); nbr_s_i = 16'($urandom);
    nbr_w_i = 16'($urandom); nbr_e_i = 16'($urandom); xl_i = 16'($urandom);
    row_peer_i = {16'($urandom), 16'($urandom), 16'($urandom)};
    col_peer_i = {16'($urandom), 16'($urandom), 16'($urandom)};
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset outputs");
    en = 1'b1;
    for (int i = 12; i < 16; i++) go(mk(0, 0, 0, 0, 0, i, 0, 0, 0), "R1 register reads zero");
    go(mk(0, 0, 1, 0, 0, 0, 0, 13, 0), "R1 accumulator reads zero");

    dbus_i = 16'd11; nbr_n_i = 16'd22; nbr_s_i = 16'd33; nbr_w_i = 16'd44; nbr_e_i = 16'hFFF0;
    row_peer_i = {16'd77, 16'd66, 16'd55}; col_peer_i = {16'd110, 16'd99, 16'd88}; xl_i = 16'h8001;
    for (int i = 0; i < 12; i++) go(mk(0, 0, i % 4, 0, 0, i, 0, 0, 0), "R2 operand A select");
    for (int i = 0; i < 4; i++) go(mk(0, 0, i, 0, 0, 0, 0, 7, 100 * (i + 1)), "R9 destination write");
    for (int i = 12; i < 16; i++) go(mk(0, 0, 0, 0, 0, i, 0, 0, 0), "R9 register read-back");
    for (int i = 0; i < 8; i++) go(mk(0, 0, 3, 0, 0, 0, i, 11, 0), "R3 operand B select");
    go(mk(0, 1, 0, 0, 0, 0, 4, 1, 0), "R3 feedback operand");
    go(mk(0, 1, 0, 0, 0, 0, 4, 1, 0), "R3 feedback again");

    dbus_i = 16'd1000; nbr_n_i = 16'hFC18;
    for (int op = 0; op < 16; op++) go(mk(0, 0, 2, 0, 0, 0, 5, op, -7), "R4 opcode sweep");
    dbus_i = 16'h8000; nbr_n_i = 16'h7FFF;
    go(mk(0, 0, 0, 0, 0, 0, 5, 3, 0), "R4 absdiff extreme");
    go(mk(0, 0, 0, 0, 0, 0, 5, 2, 0), "R8 clamp low");
    dbus_i = 16'h7FFF;
    go(mk(0, 0, 0, 0, 0, 0, 5, 1, 0), "R8 clamp high");
    go(mk(0, 0, 0, 0, 0, 0, 0, 8, -2048), "R5 product negative K");
    dbus_i = 16'd123;
    go(mk(0, 0, 0, 0, 0, 0, 0, 8, 2047), "R5 product max K");

    go(mk(0, 0, 0, 0, 0, 0, 0, 10, 0), "R6 clear");
    dbus_i = 16'h8000;
    for (int i = 0; i < 3; i++) go(mk(0, 0, 1, 1, 12, 0, 0, 9, -2048), "R6 accumulate wrap");
    go(mk(0, 0, 0, 1, 12, 0, 0, 13, 0), "R6 accumulator read");
    go(mk(0, 0, 0, 1, 0, 0, 0, 13, 0), "R6 accumulator read unshifted");
    go(mk(0, 0, 0, 0, 0, 0, 0, 10, 0), "R6 clear again");

    dbus_i = 16'hFF85;
    for (int amt = 0; amt < 16; amt += 5) begin
      go(mk(0, 0, 0, 0, amt, 0, 0, 0, 0), "R7 left shift");
      go(mk(0, 0, 0, 1, amt, 0, 0, 0, 0), "R7 right shift");
    end

    go(mk(1, 0, 0, 0, 0, 0, 0, 0, 0), "R10 flag set");
    go(mk(0, 0, 0, 0, 0, 0, 0, 0, 0), "R10 flag clear");
    go(mk(1, 0, 0, 0, 0, 0, 0, 0, 0), "R10 flag set again");

    dbus_i = 16'd5;
    go(mk(0, 0, 0, 0, 0, 0, 0, 9, 3), "R11 preload accumulator");
    en = 1'b0;
    dbus_i = 16'd999;
    go(mk(1, 0, 2, 0, 0, 0, 0, 9, 5), "R11 disabled mac");
    go(mk(0, 0, 1, 0, 0, 0, 0, 10, 0), "R11 disabled clear");
    en = 1'b1;
    go(mk(0, 0, 3, 0, 0, 0, 0, 13, 0), "R11 accumulator held");
    for (int i = 12; i < 16; i++) go(mk(0, 0, 3, 0, 0, i, 0, 0, 0), "R11 registers held");

    for (int n = 0; n < 4000; n++) begin
      scramble();
      en = ($urandom % 8) != 0;
      ctx = $urandom;
      step("R12 random context");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule